// File: doc/BRIEF.md
# Host Write Transmit Queue with Holdoff

This block turns host writes to shared memory into outgoing network messages. Each host write that an upstream filter lets through becomes one queue entry. An entry holds a 21-bit word address (byte address bits 22 down to 2), a 32-bit data word and one interrupt bit. Entries leave in arrival order on a valid/ready stream that feeds the ring inserter.

The queue has room for 1024 entries by default. When it is full, a control bit chooses what happens to one more write. With holdoff on, the block raises a wait signal that stretches the host write cycle until an entry has drained, and then takes the write. With holdoff off, the write is discarded and a sticky overflow flag records the loss. Software clears that flag by writing 1 to it.

A write that arrives in a cycle where the stream also pops an entry is always taken, even when the queue is full.

Top module: `host_txq`

## Requirements
- R1: Entries leave in the order they were accepted. `tx_valid` is high whenever the queue is not empty. The oldest entry is shown on `tx_addr`, `tx_data` and `tx_irq`, and it is removed on a clock edge where `tx_valid` and `tx_ready` are both high.
- R2: `sts_full` is high exactly when the queue holds DEPTH entries (1024 by default).
- R3: With `ctl_holdoff` = 1, a queued write (`wr_valid` and `wr_keep` high) that arrives while full and with no pop in that cycle raises `wr_wait` and is not stored. The held write is stored in the first cycle that has a pop.
- R4: A queued write that arrives while full in a cycle that also pops is stored, and `wr_wait` stays low.
- R5: With `ctl_holdoff` = 0, a queued write that arrives while full with no pop is discarded. The queue contents are unchanged, and `sts_ovf` is set on the next edge.
- R6: `sts_ovf` stays set until a cycle with `ovf_clr` = 1, and then reads 0 after that edge. If a discard happens in the same cycle as the clear, the flag stays set.
- R7: A write with `wr_keep` = 0 is ignored. It stores no entry, raises no wait and sets no overflow.
- R8: `wr_wait` is never high when `ctl_holdoff` is 0 or the queue is not full.
- R9: After reset the queue is empty, and `tx_valid`, `sts_full`, `sts_ovf` and `wr_wait` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write strobe |
| wr_keep | input | 1 | Filter decision: 1 means queue this write |
| wr_addr | input | 21 | Word address, byte address bits 22:2 |
| wr_data | input | 32 | Write data |
| wr_irq | input | 1 | Interrupt bit carried with the message |
| wr_wait | output | 1 | Stretch the host write cycle |
| ctl_holdoff | input | 1 | Control bit: 1 stalls the host when full, 0 drops the write |
| ovf_clr | input | 1 | Write-1 pulse that clears the overflow flag |
| sts_full | output | 1 | Status bit: queue full |
| sts_ovf | output | 1 | Sticky flag: a write was dropped |
| tx_valid | output | 1 | Stream entry available |
| tx_ready | input | 1 | Ring inserter takes the entry |
| tx_addr | output | 21 | Head entry address |
| tx_data | output | 32 | Head entry data |
| tx_irq | output | 1 | Head entry interrupt bit |

## Verification
The bench fills the queue to exactly 1024 entries. A design with an off-by-one in its count would report full one entry early or late, and would lose or wrap an entry when reading back. At the full boundary it drives push and pop in the same cycle. A design that tested full alone would wrongly stall or drop there. It holds a stretched write across several stall cycles and checks that the write lands once, exactly when the first pop happens; a faulty design would store it twice or never. It also checks that filtered writes and the overflow set-versus-clear collision leave the flag and contents as required.

// File: rtl/host_txq.sv
module host_txq #(
  parameter int DEPTH = 1024,
  parameter int AW    = 21,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_keep,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_irq,
  output logic          wr_wait,
  input  logic          ctl_holdoff,
  input  logic          ovf_clr,
  output logic          sts_full,
  output logic          sts_ovf,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [AW-1:0] tx_addr,
  output logic [DW-1:0] tx_data,
  output logic          tx_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int EW = AW + DW + 1;
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr, rd_ptr, count;
  logic          req, pop, accept, drop;

  assign count    = wr_ptr - rd_ptr;
  assign sts_full = (count == FULL_CNT);
  assign tx_valid = (count != '0);
  assign pop      = tx_valid & tx_ready;
  assign req      = wr_valid & wr_keep;
  assign accept   = req & (~sts_full | pop);
  assign drop     = req & sts_full & ~pop & ~ctl_holdoff;
  assign wr_wait  = req & sts_full & ~pop & ctl_holdoff;

  assign {tx_addr, tx_data, tx_irq} = mem[rd_ptr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr[PW-1:0]] <= {wr_addr, wr_data, wr_irq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      sts_ovf <= 1'b0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    rd_ptr <= rd_ptr + 1'b1;
      if (drop)         sts_ovf <= 1'b1;
      else if (ovf_clr) sts_ovf <= 1'b0;
    end
  end

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  a_r8_wait_needs_full_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wait |-> (sts_full && ctl_holdoff));

  a_r3_stall_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wait |=> sts_full);

  a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_keep && sts_full && !tx_ready && !ctl_holdoff) |=> sts_ovf);

  a_r4_pop_push_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_keep && sts_full && tx_ready) |-> !wr_wait ##1 sts_full);

  a_r1_head_stable_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_addr)));

  a_r7_filtered_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_keep |-> !wr_wait);
endmodule

// File: tb/host_txq_tb.sv
module host_txq_tb;
  localparam int DEPTH = 1024;

  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, wr_keep = 0, wr_irq = 0, ctl_holdoff = 0, ovf_clr = 0, tx_ready = 0;
  logic [20:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_wait, sts_full, sts_ovf, tx_valid, tx_irq;
  logic [20:0] tx_addr;
  logic [31:0] tx_data;

  int checks = 0, fails = 0;
  logic [53:0] q[$];
  logic        m_ovf = 0;

  always #5 clk = ~clk;

  host_txq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_keep(wr_keep),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_irq(wr_irq), .wr_wait(wr_wait),
    .ctl_holdoff(ctl_holdoff), .ovf_clr(ovf_clr), .sts_full(sts_full), .sts_ovf(sts_ovf),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_data(tx_data), .tx_irq(tx_irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic k, logic ho, logic rdy, logic clr);
    logic e_valid, e_full, e_pop, e_req, e_wait, e_acc, e_drop;
    @(negedge clk);
    wr_valid = v; wr_keep = k; ctl_holdoff = ho; tx_ready = rdy; ovf_clr = clr;
    wr_addr = 21'($urandom); wr_data = $urandom; wr_irq = 1'($urandom);
    #1;
    e_valid = (q.size() != 0);
    e_full  = (q.size() == DEPTH);
    e_pop   = e_valid & rdy;
    e_req   = v & k;
    e_wait  = e_req & e_full & ~e_pop & ho;
    e_acc   = e_req & (~e_full | e_pop);
    e_drop  = e_req & e_full & ~e_pop & ~ho;
    chk("R1 tx_valid", 64'(tx_valid), 64'(e_valid));
    if (e_valid) chk("R1 head entry", 64'({tx_addr, tx_data, tx_irq}), 64'(q[0]));
    chk("R2 sts_full", 64'(sts_full), 64'(e_full));
    chk("R3/R4/R8 wr_wait", 64'(wr_wait), 64'(e_wait));
    chk("R5/R6 sts_ovf", 64'(sts_ovf), 64'(m_ovf));
    if (e_pop) void'(q.pop_front());
    if (e_acc) q.push_back({wr_addr, wr_data, wr_irq});
    if (e_drop) m_ovf = 1;
    else if (clr) m_ovf = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #22 rst_n = 1;
    // R9 reset state
    @(negedge clk);
    chk("R9 tx_valid", 64'(tx_valid), 0);
    chk("R9 sts_full", 64'(sts_full), 0);
    chk("R9 sts_ovf", 64'(sts_ovf), 0);
    chk("R9 wr_wait", 64'(wr_wait), 0);
    // R1 ordering under mixed traffic
    for (int i = 0; i < 200; i++) step(1'($urandom), 1, 0, 1'($urandom), 0);
    for (int i = 0; i < 50; i++) step(0, 0, 0, 1, 0);
    // R7 filtered writes
    for (int i = 0; i < 10; i++) step(1, 0, 1'($urandom), 0, 0);
    // R2 fill to full, R5 drops
    for (int i = 0; i < DEPTH + 5; i++) step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R6 collision: drop together with clear keeps flag
    step(1, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R7 filtered write while full, holdoff off: no ovf
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R3 stretched write, taken on first pop
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0);
    step(0, 0, 1, 0, 0);
    // R4 push and pop in same cycle while full
    for (int i = 0; i < 8; i++) step(1, 1, 1'($urandom), 1, 0);
    // drain and random mix
    for (int i = 0; i < DEPTH + 20; i++) step(0, 0, 0, 1, 0);
    for (int i = 0; i < 1500; i++) step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 16 == 0));
    for (int i = 0; i < DEPTH + 20; i++) step(0, 0, 0, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule